// File: doc/BRIEF.md
# ATM Transmit Cell Formatter

This block turns a stream of 53-byte ATM cells into the octet stream for one TDM line channel. Cells arrive on a byte-wide valid/ready interface that carries a start-of-cell flag. They are held in a two-cell buffer. The line side asks for one octet per `line_en` pulse. The formatter writes a computed header check byte into the fifth position of each cell and can XOR a fixed coset onto it. It can also scramble the 48 payload bytes with a self-synchronizing scrambler.

Line timing is owned by the line side. A cell boundary can come up when no complete user cell is buffered. In that case the formatter sends a filler cell so the cell rate stays constant. The filler is either an idle cell or an unassigned cell, as chosen by a configuration bit. A loopback output copies the line octets so a local receiver can be fed from the transmit path.

Top module: `atm_tc_tx_fmt`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `line_valid`, `line_soc` and `lb_valid` are 0 and `cell_ready` is 1.
- R2: Each cycle with `line_en` high produces exactly one octet. That octet has `line_valid` high two clock edges later. `line_soc` is high on byte 0 of each cell and low on the other bytes, and every cell is 53 octets long.
- R3: A user cell is sent with bytes 0–3 and 5–52 unchanged when scrambling is off. Input byte 4 is ignored and replaced by the CRC-8 of bytes 0–3, using generator x^8+x^2+x+1 with initial value 0, processed MSB first, with no final XOR.
- R4: With `cfg_coset_en` = 1, the transmitted byte 4 is the CRC-8 XOR 0x55.
- R5: With `cfg_scram_en` = 1, each payload byte (5–52) is scrambled MSB first as out = in XOR (output bit sent 43 bits earlier). The scrambler state starts at zero after reset, carries across cells, and advances only on scrambled payload bytes. Header bytes and the check byte are never scrambled.
- R6: If no complete user cell is buffered when byte 0 is due, a filler cell is sent. Its header is 00 00 00 01 (idle, `cfg_fill_unassigned` = 0) or 00 00 00 00 (unassigned, = 1), and its payload bytes are all 0x6A. The check byte, coset and scrambling apply to filler cells as they do to user cells.
- R7: An input byte with `cell_sop` = 1 starts a new cell at position 0, even when a cell is half written; the partial cell is dropped. Bytes with `cell_sop` = 0 while no cell is open are accepted and dropped. A cell is complete after its 53rd byte.
- R8: Up to two complete cells are buffered. `cell_ready` is 0 while both are held, and cells leave in the order they arrived.
- R9: `cfg_scram_en`, `cfg_coset_en` and `cfg_fill_unassigned` are sampled with byte 0 of each cell. A change made in the middle of a cell takes effect with the next cell.
- R10: With `cfg_loop_en` = 1, `lb_valid` and `lb_data` follow `line_valid` and `line_data`. With `cfg_loop_en` = 0, `lb_valid` is 0 and `lb_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scram_en | input | 1 | Scramble payload bytes |
| cfg_coset_en | input | 1 | XOR 0x55 onto the check byte |
| cfg_fill_unassigned | input | 1 | Filler type: 0 idle, 1 unassigned |
| cfg_loop_en | input | 1 | Enable loopback copy |
| cell_valid | input | 1 | Input byte valid |
| cell_sop | input | 1 | Input byte is cell byte 0 |
| cell_data | input | 8 | Input cell byte |
| cell_ready | output | 1 | Input byte accepted when high with `cell_valid` |
| line_en | input | 1 | Request one line octet |
| line_data | output | 8 | Line octet |
| line_valid | output | 1 | `line_data` carries a new octet |
| line_soc | output | 1 | Octet is byte 0 of a cell |
| lb_valid | output | 1 | Loopback octet valid |
| lb_data | output | 8 | Loopback octet |

## Verification
Intake and emission can happen in the same cycle. A new cell can be written into the slot just freed while the other slot is being read out and scrambled. The bench preloads two cells, then feeds a third as soon as `cell_ready` returns, with line requests every third cycle. A correct result is three user cells in arrival order followed by one filler cell, with every byte matching the model. A configuration change is also made during the same cycle stream, partway through a cell. It must show up only from the next cell boundary.

// File: rtl/atm_tc_pkg.sv
package atm_tc_pkg;

  localparam logic [7:0] HEC_POLY = 8'h07;

  typedef struct packed {
    logic scram;
    logic coset;
    logic unassigned;
  } tc_cfg_t;

  // one byte of CRC-8 (x^8+x^2+x+1), MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] d);
    logic [7:0] r;
    r = crc_in;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ HEC_POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/atm_tc_cell_buf.sv
module atm_tc_cell_buf #(
  parameter int CELL_BYTES = 53,
  parameter int NUM_SLOTS  = 2,
  localparam int IDX_W  = $clog2(CELL_BYTES),
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int DEPTH  = NUM_SLOTS << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             wr_sop,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_release,
  output logic             rd_avail,
  output logic [7:0]       rd_q
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [7:0]           mem [DEPTH];
  logic [NUM_SLOTS-1:0] full_q;
  logic [SLOT_W-1:0]    wr_slot_q, rd_slot_q;
  logic [IDX_W-1:0]     wr_idx_q;
  logic                 open_q;

  logic                 accept, wr_en, wr_done;
  logic [IDX_W-1:0]     wr_pos;

  assign wr_ready = ~full_q[wr_slot_q];
  assign rd_avail = full_q[rd_slot_q];
  assign accept   = wr_valid & wr_ready;
  assign wr_en    = accept & (wr_sop | open_q);
  assign wr_pos   = wr_sop ? '0 : wr_idx_q;
  assign wr_done  = wr_en & (wr_pos == LAST_IDX);

  // simple dual-port RAM, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_slot_q, wr_pos}] <= wr_data;
    if (rd_en) rd_q <= mem[{rd_slot_q, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx_q  <= '0;
      wr_slot_q <= '0;
      open_q    <= 1'b0;
    end else if (wr_en) begin
      if (wr_done) begin
        wr_idx_q  <= '0;
        open_q    <= 1'b0;
        wr_slot_q <= (wr_slot_q == LAST_SLOT) ? '0 : wr_slot_q + 1'b1;
      end else begin
        wr_idx_q <= wr_pos + 1'b1;
        open_q   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= '0;
      rd_slot_q <= '0;
    end else begin
      if (wr_done) full_q[wr_slot_q] <= 1'b1;
      if (rd_release) begin
        full_q[rd_slot_q] <= 1'b0;
        rd_slot_q <= (rd_slot_q == LAST_SLOT) ? '0 : rd_slot_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/atm_tc_octet_proc.sv
module atm_tc_octet_proc
  import atm_tc_pkg::*;
#(
  parameter int         CELL_BYTES = 53,
  parameter int         HDR_BYTES  = 4,
  parameter int         SCR_LEN    = 43,
  parameter logic [7:0] COSET_BYTE = 8'h55,
  parameter logic [7:0] FILL_BYTE  = 8'h6A,
  localparam int IDX_W = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_user,
  input  tc_cfg_t          in_cfg,
  input  logic [7:0]       in_q,
  input  logic             loop_en,
  output logic [7:0]       line_data,
  output logic             line_valid,
  output logic             line_soc,
  output logic             lb_valid,
  output logic [7:0]       lb_data
);

  localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_BYTES);

  logic [7:0]         crc_q, crc_next, raw, scr, out_byte;
  logic [SCR_LEN-1:0] hist_q, hist_w;
  logic               is_hdr, is_hec, is_pay;

  assign is_hdr = in_idx < HEC_IDX;
  assign is_hec = in_idx == HEC_IDX;
  assign is_pay = ~is_hdr & ~is_hec;

  always_comb begin
    if (in_user)     raw = in_q;
    else if (is_hdr) raw = {7'd0, (in_idx == HEC_IDX - 1'b1) & ~in_cfg.unassigned};
    else             raw = FILL_BYTE;
  end

  assign crc_next = crc8_step((in_idx == '0) ? 8'h00 : crc_q, raw);

  always_comb begin
    hist_w = hist_q;
    scr    = '0;
    for (int i = 7; i >= 0; i--) begin
      scr[i] = raw[i] ^ hist_w[SCR_LEN-1];
      hist_w = {hist_w[SCR_LEN-2:0], scr[i]};
    end
  end

  always_comb begin
    if (is_hdr)      out_byte = raw;
    else if (is_hec) out_byte = crc_q ^ (in_cfg.coset ? COSET_BYTE : 8'h00);
    else             out_byte = in_cfg.scram ? scr : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q      <= '0;
      hist_q     <= '0;
      line_data  <= '0;
      line_valid <= 1'b0;
      line_soc   <= 1'b0;
      lb_valid   <= 1'b0;
      lb_data    <= '0;
    end else begin
      line_valid <= in_valid;
      line_soc   <= in_valid & (in_idx == '0);
      lb_valid   <= in_valid & loop_en;
      lb_data    <= (in_valid & loop_en) ? out_byte : 8'h00;
      if (in_valid) begin
        line_data <= out_byte;
        if (is_hdr) crc_q <= crc_next;
        if (is_pay && in_cfg.scram) hist_q <= hist_w;
      end
    end
  end

endmodule

// File: rtl/atm_tc_tx_fmt.sv
module atm_tc_tx_fmt
  import atm_tc_pkg::*;
#(
  parameter int         CELL_BYTES = 53,
  parameter int         HDR_BYTES  = 4,
  parameter int         NUM_SLOTS  = 2,
  parameter int         SCR_LEN    = 43,
  parameter logic [7:0] COSET_BYTE = 8'h55,
  parameter logic [7:0] FILL_BYTE  = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_scram_en,
  input  logic       cfg_coset_en,
  input  logic       cfg_fill_unassigned,
  input  logic       cfg_loop_en,
  input  logic       cell_valid,
  input  logic       cell_sop,
  input  logic [7:0] cell_data,
  output logic       cell_ready,
  input  logic       line_en,
  output logic [7:0] line_data,
  output logic       line_valid,
  output logic       line_soc,
  output logic       lb_valid,
  output logic [7:0] lb_data
);

  localparam int               IDX_W    = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] rd_idx_q, s1_idx;
  logic             cur_user_q, s1_user, s1_valid;
  tc_cfg_t          cur_cfg_q, s1_cfg, cfg_in, cfg_now;
  logic             at_start, last, use_user, rd_avail, rd_release;
  logic [7:0]       rd_q;

  assign cfg_in     = '{scram: cfg_scram_en, coset: cfg_coset_en, unassigned: cfg_fill_unassigned};
  assign at_start   = rd_idx_q == '0;
  assign last       = rd_idx_q == LAST_IDX;
  assign use_user   = at_start ? rd_avail : cur_user_q;
  assign cfg_now    = at_start ? cfg_in : cur_cfg_q;
  assign rd_release = line_en & last & use_user;

  atm_tc_cell_buf #(.CELL_BYTES(CELL_BYTES), .NUM_SLOTS(NUM_SLOTS)) u_buf (
    .clk(clk), .rst(rst),
    .wr_valid(cell_valid), .wr_sop(cell_sop), .wr_data(cell_data), .wr_ready(cell_ready),
    .rd_en(line_en), .rd_idx(rd_idx_q), .rd_release(rd_release),
    .rd_avail(rd_avail), .rd_q(rd_q)
  );

  // cell position sequencer: the user/filler choice and config are fixed at byte 0
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx_q   <= '0;
      cur_user_q <= 1'b0;
      cur_cfg_q  <= '0;
      s1_valid   <= 1'b0;
      s1_idx     <= '0;
      s1_user    <= 1'b0;
      s1_cfg     <= '0;
    end else begin
      s1_valid <= line_en;
      if (line_en) begin
        s1_idx     <= rd_idx_q;
        s1_user    <= use_user;
        s1_cfg     <= cfg_now;
        cur_user_q <= use_user;
        cur_cfg_q  <= cfg_now;
        rd_idx_q   <= last ? '0 : rd_idx_q + 1'b1;
      end
    end
  end

  atm_tc_octet_proc #(
    .CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES), .SCR_LEN(SCR_LEN),
    .COSET_BYTE(COSET_BYTE), .FILL_BYTE(FILL_BYTE)
  ) u_proc (
    .clk(clk), .rst(rst),
    .in_valid(s1_valid), .in_idx(s1_idx), .in_user(s1_user), .in_cfg(s1_cfg), .in_q(rd_q),
    .loop_en(cfg_loop_en),
    .line_data(line_data), .line_valid(line_valid), .line_soc(line_soc),
    .lb_valid(lb_valid), .lb_data(lb_data)
  );

endmodule

// File: rtl/atm_tc_tx_fmt_chk.sv
module atm_tc_tx_fmt_chk
  import atm_tc_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       line_en,
  input logic [7:0] line_data,
  input logic       line_valid,
  input logic       line_soc,
  input logic       lb_valid,
  input logic [7:0] lb_data
);

  logic [15:0] pos_q;
  logic        started_q;
  logic [7:0]  crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      started_q <= 1'b0;
      crc_q     <= '0;
    end else if (line_valid) begin
      if (line_soc) begin
        pos_q     <= 16'd1;
        started_q <= 1'b1;
        crc_q     <= crc8_step(8'h00, line_data);
      end else begin
        pos_q <= pos_q + 1'b1;
        if (pos_q < 16'(HDR_BYTES)) crc_q <= crc8_step(crc_q, line_data);
      end
    end
  end

  assert_out_latency_R2: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> $past(line_en, 2));

  assert_soc_valid_R2: assert property (@(posedge clk) disable iff (rst)
    line_soc |-> line_valid);

  assert_cell_len_R2: assert property (@(posedge clk) disable iff (rst)
    (line_valid && line_soc && started_q) |-> (pos_q == 16'(CELL_BYTES)));

  assert_first_is_soc_R2: assert property (@(posedge clk) disable iff (rst)
    (line_valid && !started_q) |-> line_soc);

  // R3 / R4: the check byte is the header CRC, optionally with the coset
  assert_hec_R3: assert property (@(posedge clk) disable iff (rst)
    (line_valid && !line_soc && pos_q == 16'(HDR_BYTES)) |->
      (line_data == crc_q || line_data == (crc_q ^ 8'h55)));

  assert_loop_copy_R10: assert property (@(posedge clk) disable iff (rst)
    lb_valid |-> (line_valid && lb_data == line_data));

  assert_loop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !lb_valid |-> (lb_data == 8'h00));

endmodule

bind atm_tc_tx_fmt atm_tc_tx_fmt_chk #(.CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES)) u_chk (
  .clk(clk), .rst(rst), .line_en(line_en), .line_data(line_data), .line_valid(line_valid),
  .line_soc(line_soc), .lb_valid(lb_valid), .lb_data(lb_data)
);

// File: tb/atm_tc_tx_fmt_bench.sv
module atm_tc_tx_fmt_bench;

  localparam int CB = 53;
  typedef logic [7:0] cell_t [CB];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_scram_en = 0, cfg_coset_en = 0, cfg_fill_unassigned = 0, cfg_loop_en = 0;
  logic cell_valid = 0, cell_sop = 0;
  logic [7:0] cell_data = 0;
  logic cell_ready;
  logic line_en = 0;
  logic [7:0] line_data, lb_data;
  logic line_valid, line_soc, lb_valid;

  always #5 clk = ~clk;

  atm_tc_tx_fmt u_atm_tc_tx_fmt (
    .clk(clk), .rst(rst),
    .cfg_scram_en(cfg_scram_en), .cfg_coset_en(cfg_coset_en),
    .cfg_fill_unassigned(cfg_fill_unassigned), .cfg_loop_en(cfg_loop_en),
    .cell_valid(cell_valid), .cell_sop(cell_sop), .cell_data(cell_data), .cell_ready(cell_ready),
    .line_en(line_en), .line_data(line_data), .line_valid(line_valid), .line_soc(line_soc),
    .lb_valid(lb_valid), .lb_data(lb_data)
  );

  int checks = 0, fails = 0;
  int pulse_cnt = 0;
  int lb_err = 0;
  logic loop_exp = 0;
  logic [42:0] bscr = '0;
  logic [7:0] ucell_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] cap_q[$];
  logic       capsoc_q[$];
  logic [2:0] flags_q[$];   // {user, scram, coset}

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected octets of one cell, in order
  task automatic add_exp(input bit user, input bit scr, input bit cos, input bit unas);
    logic [7:0] c [CB];
    logic [7:0] crc = 8'h00;
    for (int i = 0; i < CB; i++) begin
      if (user) c[i] = ucell_q.pop_front();
      else if (i < 4) c[i] = (i == 3 && !unas) ? 8'h01 : 8'h00;
      else c[i] = 8'h6A;
    end
    for (int i = 0; i < 4; i++) crc = bcrc(crc, c[i]);
    c[4] = crc ^ (cos ? 8'h55 : 8'h00);
    if (scr) begin
      for (int i = 5; i < CB; i++) begin
        for (int b = 7; b >= 0; b--) begin
          c[i][b] = c[i][b] ^ bscr[42];
          bscr = {bscr[41:0], c[i][b]};
        end
      end
    end
    for (int i = 0; i < CB; i++) exp_q.push_back(c[i]);
    flags_q.push_back({user, scr, cos});
  endtask

  task automatic gen_cell(output cell_t c);
    for (int i = 0; i < CB; i++) begin
      c[i] = 8'($urandom);
      ucell_q.push_back(c[i]);
    end
  endtask

  task automatic wr_byte(input logic sop, input logic [7:0] d);
    cell_valid = 1; cell_sop = sop; cell_data = d;
    while (!cell_ready) @(negedge clk);
    @(negedge clk);
    cell_valid = 0; cell_sop = 0;
  endtask

  task automatic send_cell(input cell_t c);
    for (int i = 0; i < CB; i++) wr_byte(i == 0, c[i]);
  endtask

  task automatic run_pulses(input int n, input int gap);
    for (int p = 0; p < n; p++) begin
      line_en = 1; pulse_cnt++;
      @(negedge clk);
      if (gap > 0) begin
        line_en = 0;
        repeat (gap) @(negedge clk);
      end
    end
    line_en = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input bit s, input bit c, input bit u, input bit l);
    cfg_scram_en = s; cfg_coset_en = c; cfg_fill_unassigned = u; cfg_loop_en = l; loop_exp = l;
  endtask

  task automatic check_stream(input string scen);
    checks++;
    if (cap_q.size() != exp_q.size()) begin
      fails++;
      $display("FAIL R2 (%s) octet count actual=%0d expected=%0d", scen, cap_q.size(), exp_q.size());
    end else begin
      for (int c = 0; c < flags_q.size(); c++) begin
        int bad = -1;
        string tag;
        for (int b = 0; b < CB; b++) begin
          if (bad < 0 && (cap_q[c*CB+b] !== exp_q[c*CB+b] || capsoc_q[c*CB+b] !== (b == 0))) bad = b;
        end
        if (bad < 0) checks++;
        else begin
          if (capsoc_q[c*CB+bad] !== (bad == 0)) tag = "R2";
          else if (bad == 4) tag = flags_q[c][0] ? "R4" : "R3";
          else if (bad > 4 && flags_q[c][1]) tag = "R5";
          else if (flags_q[c][2]) tag = "R3";
          else tag = "R6";
          chk(0, $sformatf("%s (%s) cell %0d byte %0d", tag, scen, c, bad),
              cap_q[c*CB+bad], exp_q[c*CB+bad]);
        end
      end
    end
    chk(lb_err == 0, $sformatf("R10 (%s) loopback mismatches", scen), lb_err, 0);
    lb_err = 0;
    cap_q.delete(); capsoc_q.delete(); exp_q.delete(); flags_q.delete();
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (line_valid) begin
        cap_q.push_back(line_data);
        capsoc_q.push_back(line_soc);
        if (lb_valid !== loop_exp || (loop_exp && lb_data !== line_data)) lb_err++;
      end else if (lb_valid !== 1'b0) lb_err++;
      if (!lb_valid && lb_data !== 8'h00) lb_err++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    cell_t ca, cb, cc;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk(line_valid === 0 && line_soc === 0 && lb_valid === 0, "R1 outputs in reset", line_valid, 0);
    chk(cell_ready === 1, "R1 ready in reset", cell_ready, 1);
    rst = 0;
    @(negedge clk);
    chk(line_valid === 0 && lb_valid === 0 && cell_ready === 1, "R1 after reset", line_valid, 0);

    // R2 latency and R6 idle filler, no coset
    set_cfg(0, 0, 0, 0);
    line_en = 1; @(negedge clk); line_en = 0;
    chk(line_valid === 0, "R2 one edge after request", line_valid, 0);
    @(negedge clk);
    chk(line_valid === 1 && line_soc === 1, "R2 two edges after request", {line_valid, line_soc}, 3);
    run_pulses(CB - 1, 1);
    chk(cap_q.size() > 4 && cap_q[4] === 8'h07, "R6 idle check byte", cap_q.size() > 4 ? cap_q[4] : 0, 8'h07);
    add_exp(0, 0, 0, 0);
    check_stream("R6 idle");

    // R4 coset on unassigned filler
    set_cfg(0, 1, 1, 1);
    run_pulses(CB, 0);
    chk(cap_q.size() > 4 && cap_q[4] === 8'h55, "R4 unassigned check byte with coset",
        cap_q.size() > 4 ? cap_q[4] : 0, 8'h55);
    add_exp(0, 0, 1, 1);
    check_stream("R4");

    // R8 two buffered cells, third written while the line runs
    set_cfg(1, 0, 0, 1);
    gen_cell(ca); send_cell(ca);
    gen_cell(cb); send_cell(cb);
    @(negedge clk);
    chk(cell_ready === 0, "R8 ready low with two cells held", cell_ready, 0);
    gen_cell(cc);
    add_exp(1, 1, 0, 0); add_exp(1, 1, 0, 0); add_exp(1, 1, 0, 0); add_exp(0, 1, 0, 0);
    fork
      run_pulses(4 * CB, 2);
      send_cell(cc);
    join
    check_stream("R8 concurrent");

    // R7 stray bytes dropped, partial cell restarted by a new start flag
    set_cfg(0, 1, 0, 0);
    wr_byte(0, 8'hAA); wr_byte(0, 8'hBB);
    for (int i = 0; i < 10; i++) wr_byte(i == 0, 8'hEE);
    gen_cell(ca); send_cell(ca);
    wr_byte(0, 8'hCC);
    add_exp(1, 0, 1, 0); add_exp(0, 0, 1, 0);
    run_pulses(2 * CB, 1);
    check_stream("R7");

    // R9 config change in the middle of a filler cell
    set_cfg(0, 0, 0, 0);
    add_exp(0, 0, 0, 0); add_exp(0, 1, 1, 1);
    pulse_cnt = 0;
    fork
      run_pulses(2 * CB, 0);
      begin
        wait (pulse_cnt == 20);
        @(negedge clk);
        cfg_scram_en = 1; cfg_coset_en = 1; cfg_fill_unassigned = 1;
      end
    join
    check_stream("R9");

    // random mix
    for (int it = 0; it < 8; it++) begin
      int n = $urandom % 3;
      int gap = $urandom % 3;
      bit s = 1'($urandom), c = 1'($urandom), u = 1'($urandom), l = 1'($urandom);
      set_cfg(s, c, u, l);
      for (int k = 0; k < n; k++) begin
        if ($urandom % 2) wr_byte(0, 8'($urandom));
        gen_cell(ca); send_cell(ca);
      end
      if (n == 2) begin
        @(negedge clk);
        chk(cell_ready === 0, "R8 random full buffer", cell_ready, 0);
      end
      for (int k = 0; k < n; k++) add_exp(1, s, c, u);
      add_exp(0, s, c, u);
      run_pulses((n + 1) * CB, gap);
      check_stream("random R3 R5 R6");
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule